// File: doc/BRIEF.md
# Excessive Error Defect Detector

This block takes the number of multiplex-section parity errors found in each received frame, together with a strobe that marks the frame. It keeps two running tallies. The first is a block tally of frames that carried any error. The second is a bit tally of all error bits. Both tallies stop at their maximum value.

The block also decides whether the link suffers from an excessive error defect. A frame is marked errored when its error count is above a programmable per-frame limit. The block then counts how many errored frames fall inside a sliding window whose length, in frames, is programmable. The defect is raised once that count reaches a raise threshold. It drops only after a completely filled window holds fewer errored frames than a lower drop threshold. Choosing the window length, the per-frame limit and the two thresholds places the detector anywhere from very high to very low error rates.

An enable input lets an active defect request alarm indication signal (AIS) insertion downstream.

Top module: `eed_detector`

## Requirements
- R1: After reset, both tallies read zero, the defect flag is low and the AIS request is low.
- R2: On a strobed frame with a nonzero error count, the block tally increases by one. A strobed frame with zero errors leaves it unchanged, and so does any cycle without a strobe.
- R3: The 13-bit block tally holds at 8191 instead of wrapping.
- R4: On each strobed frame, the 18-bit bit tally adds that frame's error count. It holds at 262143 instead of wrapping, and it never changes without a strobe.
- R5: A frame is errored only when its error count is strictly greater than the per-frame limit. A count equal to the limit is a clean frame.
- R6: The defect flag rises in the cycle after the strobe for which the errored frames among the last L frames, the current one included, reach the raise threshold.
- R7: Frames older than the last L frames no longer count toward the window.
- R8: While the defect is active, it drops only on a strobe after which the window holds L frames and fewer than the drop threshold of them are errored. A count at or above the drop threshold keeps the defect active.
- R9: A change of the window-length input empties the window and restarts its fill. A frame strobed in the same cycle as the change is left out of the window, though the tallies still count it.
- R10: A window length of 0 acts as 1. A window length above MAX_WIN (default 64) acts as MAX_WIN.
- R11: The AIS request equals the defect flag ANDed with the AIS enable, with no added delay.
- R12: The defect flag changes only on a strobed frame. Changing the thresholds alone does not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| frame_errs | input | ERR_W (8) | Parity error bits found in this frame |
| win_len | input | WIN_W (7) | Window length in frames |
| frame_thr | input | ERR_W (8) | Per-frame limit; a frame above it is errored |
| set_thr | input | WIN_W (7) | Errored frames in the window that raise the defect |
| clr_thr | input | WIN_W (7) | Errored-frame count below which a full window drops the defect |
| ais_en | input | 1 | Lets an active defect request AIS |
| blk_cnt | output | 13 | Saturating block error tally |
| bit_cnt | output | 18 | Saturating bit error tally |
| eed | output | 1 | Excessive error defect flag |
| ais_req | output | 1 | AIS insertion request |

## Verification
A pattern in which an old errored frame should already have left the window catches a design that keeps a cumulative count: such a design would raise the defect too early. The drop side is tested at counts between the two thresholds, which a design without hysteresis would clear. It is also tested just after a window restart, where a design that ignores the fill state would clear on one clean frame. Per-frame counts exactly at the limit, a strobe coinciding with a window-length change, and the clamping of out-of-range window lengths are each tested. Long runs check that both tallies stop at their maximum instead of wrapping back toward zero.

// File: rtl/eed_pkg.sv
package eed_pkg;
  typedef enum logic {
    EED_OFF = 1'b0,
    EED_ON  = 1'b1
  } eed_state_e;
endpackage

// File: rtl/eed_err_counters.sv
module eed_err_counters #(
  parameter int ERR_W = 8,
  parameter int BLK_W = 13,
  parameter int BIT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [ERR_W-1:0] errs,
  output logic [BLK_W-1:0] blk_cnt,
  output logic [BIT_W-1:0] bit_cnt
);
  localparam int SUM_W = BIT_W + 1;

  logic [BLK_W-1:0] blk_q, blk_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [SUM_W-1:0] bit_sum;

  always_comb begin
    blk_d = blk_q;
    if ((errs != '0) && (blk_q != '1)) blk_d = blk_q + 1'b1;
    bit_sum = SUM_W'(bit_q) + SUM_W'(errs);
    bit_d   = bit_sum[BIT_W] ? '1 : bit_sum[BIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      bit_q <= '0;
    end else if (stb) begin
      blk_q <= blk_d;
      bit_q <= bit_d;
    end
  end

  assign blk_cnt = blk_q;
  assign bit_cnt = bit_q;
endmodule

// File: rtl/eed_window.sv
module eed_window #(
  parameter int ERR_W   = 8,
  parameter int MAX_WIN = 64,
  parameter int WIN_W   = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [ERR_W-1:0] errs,
  input  logic [ERR_W-1:0] frame_thr,
  input  logic [WIN_W-1:0] win_len,
  output logic             upd,
  output logic [WIN_W-1:0] sum_nxt,
  output logic             full_nxt
);
  localparam int PTR_W = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
  localparam logic [WIN_W-1:0] MAX_LEN = WIN_W'(MAX_WIN);

  logic [MAX_WIN-1:0] ring_q;
  logic [WIN_W-1:0]   len_q, eff_len, ptr_q, ptr_d, fill_q, fill_d, sum_q;
  logic               restart, flag, old_flag;

  always_comb begin
    if (win_len == '0)          eff_len = WIN_W'(1);
    else if (win_len > MAX_LEN) eff_len = MAX_LEN;
    else                        eff_len = win_len;
  end

  assign restart  = (eff_len != len_q);
  assign upd      = stb && !restart;
  assign flag     = (errs > frame_thr);
  assign old_flag = ring_q[ptr_q[PTR_W-1:0]];

  always_comb begin
    sum_nxt  = sum_q + WIN_W'(flag) - WIN_W'(old_flag);
    ptr_d    = (ptr_q == eff_len - 1'b1) ? '0 : ptr_q + 1'b1;
    fill_d   = (fill_q == eff_len) ? fill_q : fill_q + 1'b1;
    full_nxt = (fill_d == eff_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= '0;
      len_q  <= '0;
      ptr_q  <= '0;
      fill_q <= '0;
      sum_q  <= '0;
    end else if (restart) begin
      ring_q <= '0;
      len_q  <= eff_len;
      ptr_q  <= '0;
      fill_q <= '0;
      sum_q  <= '0;
    end else if (upd) begin
      ring_q[ptr_q[PTR_W-1:0]] <= flag;
      ptr_q  <= ptr_d;
      fill_q <= fill_d;
      sum_q  <= sum_nxt;
    end
  end
endmodule

// File: rtl/eed_decider.sv
module eed_decider
  import eed_pkg::*;
#(
  parameter int WIN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [WIN_W-1:0] sum_nxt,
  input  logic             full_nxt,
  input  logic [WIN_W-1:0] set_thr,
  input  logic [WIN_W-1:0] clr_thr,
  output logic             eed
);
  eed_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (upd) begin
      case (state_q)
        EED_OFF: if (sum_nxt >= set_thr) state_d = EED_ON;
        EED_ON:  if (full_nxt && (sum_nxt < clr_thr)) state_d = EED_OFF;
        default: state_d = EED_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= EED_OFF;
    else        state_q <= state_d;
  end

  assign eed = (state_q == EED_ON);
endmodule

// File: rtl/eed_detector.sv
module eed_detector #(
  parameter int ERR_W   = 8,
  parameter int MAX_WIN = 64,
  parameter int BLK_W   = 13,
  parameter int BIT_W   = 18,
  parameter int WIN_W   = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [ERR_W-1:0] frame_errs,
  input  logic [WIN_W-1:0] win_len,
  input  logic [ERR_W-1:0] frame_thr,
  input  logic [WIN_W-1:0] set_thr,
  input  logic [WIN_W-1:0] clr_thr,
  input  logic             ais_en,
  output logic [BLK_W-1:0] blk_cnt,
  output logic [BIT_W-1:0] bit_cnt,
  output logic             eed,
  output logic             ais_req
);
  logic             rst_s1, rst_sync_n, upd, full_nxt;
  logic [WIN_W-1:0] sum_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  eed_err_counters #(.ERR_W(ERR_W), .BLK_W(BLK_W), .BIT_W(BIT_W)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stb     (frame_stb),
    .errs    (frame_errs),
    .blk_cnt (blk_cnt),
    .bit_cnt (bit_cnt)
  );

  eed_window #(.ERR_W(ERR_W), .MAX_WIN(MAX_WIN), .WIN_W(WIN_W)) i_win (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stb       (frame_stb),
    .errs      (frame_errs),
    .frame_thr (frame_thr),
    .win_len   (win_len),
    .upd       (upd),
    .sum_nxt   (sum_nxt),
    .full_nxt  (full_nxt)
  );

  eed_decider #(.WIN_W(WIN_W)) i_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd      (upd),
    .sum_nxt  (sum_nxt),
    .full_nxt (full_nxt),
    .set_thr  (set_thr),
    .clr_thr  (clr_thr),
    .eed      (eed)
  );

  assign ais_req = eed && ais_en;
endmodule

// File: rtl/eed_detector_chk.sv
module eed_detector_chk #(
  parameter int BLK_W = 13,
  parameter int BIT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_stb,
  input logic [BLK_W-1:0] blk_cnt,
  input logic [BIT_W-1:0] bit_cnt,
  input logic             eed
);
  a_r2_blk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(blk_cnt));

  a_r3_blk_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_cnt == '1) |=> (blk_cnt == '1));

  a_r4_bit_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bit_cnt >= $past(bit_cnt)));

  a_r4_bit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(bit_cnt));

  a_r12_eed_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(eed));
endmodule

bind eed_detector eed_detector_chk #(.BLK_W(BLK_W), .BIT_W(BIT_W)) i_chk (.*);

// File: tb/test_eed_detector.sv
`timescale 1ns/1ps
module test_eed_detector;
  localparam int ERR_W = 8, MAX_WIN = 64, WIN_W = 7;

  logic             clk = 1'b0;
  logic             rst_n, frame_stb, ais_en;
  logic [ERR_W-1:0] frame_errs, frame_thr;
  logic [WIN_W-1:0] win_len, set_thr, clr_thr;
  logic [12:0]      blk_cnt;
  logic [17:0]      bit_cnt;
  logic             eed, ais_req;
  int               n_chk = 0, n_err = 0;
  bit               done = 1'b0;

  always #2 clk = ~clk;

  eed_detector i_eed_detector (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_errs(frame_errs),
    .win_len(win_len), .frame_thr(frame_thr), .set_thr(set_thr),
    .clr_thr(clr_thr), .ais_en(ais_en), .blk_cnt(blk_cnt), .bit_cnt(bit_cnt),
    .eed(eed), .ais_req(ais_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int len, input int fthr, input int sthr, input int cthr);
    @(negedge clk);
    rst_n = 1'b0; frame_stb = 1'b0; frame_errs = '0; ais_en = 1'b0;
    win_len = WIN_W'(len); frame_thr = ERR_W'(fthr);
    set_thr = WIN_W'(sthr); clr_thr = WIN_W'(cthr);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe(input int e);
    frame_stb = 1'b1; frame_errs = ERR_W'(e);
    @(negedge clk);
    frame_stb = 1'b0; frame_errs = '0;
  endtask

  task automatic t_reset();
    do_reset(4, 0, 2, 1);
    check("R1 blk", blk_cnt, 0);
    check("R1 bit", bit_cnt, 0);
    check("R1 eed", eed, 0);
    check("R1 ais", ais_req, 0);
  endtask

  task automatic t_tallies();
    do_reset(4, 200, 60, 1);
    strobe(5); strobe(0); strobe(3);
    check("R2 blk after 5,0,3", blk_cnt, 2);
    check("R4 bit after 5,0,3", bit_cnt, 8);
    frame_errs = 8'd9; repeat (3) @(negedge clk); frame_errs = '0;
    check("R2 blk no strobe", blk_cnt, 2);
    check("R4 bit no strobe", bit_cnt, 8);
  endtask

  task automatic t_limit_and_set();
    do_reset(4, 3, 2, 1);
    strobe(3); strobe(3);
    check("R5 count at limit is clean", eed, 0);
    strobe(4);
    check("R6 one errored below raise", eed, 0);
    strobe(4);
    check("R6 raise at threshold", eed, 1);
  endtask

  task automatic t_slide();
    do_reset(4, 0, 3, 1);
    strobe(1); strobe(0); strobe(0); strobe(0); strobe(1); strobe(1);
    check("R7 old frame aged out", eed, 0);
    strobe(1);
    check("R7 three in last four", eed, 1);
  endtask

  task automatic t_hysteresis();
    do_reset(4, 0, 3, 1);
    strobe(1); strobe(1); strobe(1); strobe(1);
    check("R6 raised", eed, 1);
    strobe(0); strobe(0);
    check("R8 hold at two", eed, 1);
    strobe(0);
    check("R8 hold at one", eed, 1);
    clr_thr = 7'd10;
    repeat (4) @(negedge clk);
    check("R12 threshold change alone", eed, 1);
    ais_en = 1'b1; #1;
    check("R11 ais follows enable", ais_req, 1);
    ais_en = 1'b0; #1;
    check("R11 ais off when disabled", ais_req, 0);
    clr_thr = 7'd1;
    @(negedge clk);
    strobe(0);
    check("R8 drop below threshold on full window", eed, 0);
  endtask

  task automatic t_restart();
    do_reset(4, 0, 2, 1);
    strobe(1); strobe(1);
    check("R6 raised before restart", eed, 1);
    win_len = 7'd8; @(negedge clk);
    strobe(0);
    check("R9 partial window holds defect", eed, 1);
    repeat (6) strobe(0);
    check("R9 still partial after seven", eed, 1);
    strobe(0);
    check("R9 drop on eighth clean frame", eed, 0);
    // strobe coinciding with a length change
    do_reset(2, 0, 1, 1);
    win_len = 7'd3;
    strobe(1);
    check("R9 strobe on change left out", eed, 0);
    check("R9 tally still counts", blk_cnt, 1);
    strobe(1);
    check("R9 next frame counted", eed, 1);
  endtask

  task automatic t_clamp();
    do_reset(0, 0, 1, 1);
    strobe(1);
    check("R10 zero length raise", eed, 1);
    strobe(0);
    check("R10 zero length acts as one", eed, 0);
    do_reset(100, 0, 64, 1);
    repeat (63) strobe(1);
    check("R10 below 64 errored", eed, 0);
    strobe(1);
    check("R10 raise at 64", eed, 1);
    repeat (63) strobe(0);
    check("R10 hold with one left", eed, 1);
    strobe(0);
    check("R10 length clamped to 64", eed, 0);
  endtask

  task automatic t_saturate();
    do_reset(4, 255, 60, 1);
    repeat (8200) strobe(255);
    check("R3 block tally holds at max", blk_cnt, 8191);
    check("R4 bit tally holds at max", bit_cnt, 262143);
  endtask

  initial begin
    t_reset();
    t_tallies();
    t_limit_and_set();
    t_slide();
    t_hysteresis();
    t_restart();
    t_clamp();
    t_saturate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule